// File: doc/BRIEF.md
# Page Transfer Control and Interrupt Unit

This block starts and tracks whole-page moves between an internal page buffer and a NAND flash device, and it owns the interrupt status logic around those moves. Software writes a transfer-control word that holds the direction, the main-area and spare-area enables, the burst enables, the address-cycle mode and the chip select. It sets the start bit in the same write. The start bit then serves as the busy flag. It drives a request to a pin-level sequencer, and it clears itself when the sequencer reports completion. Completion raises a transfer-done interrupt source.

Two more interrupt sources come from an external ECC engine: a corrected-error pulse and an uncorrectable-error pulse. Each of the three sources has its own status bit, which latches on its event whether or not the source is enabled. One enable mask gates the single interrupt line. A write-one-to-clear register retires status bits. The pin protocol, the ECC arithmetic and bus mastering live outside this block.

Register word offsets: 0x00 transfer control, 0x04 length, 0x08 interrupt enable, 0x0C interrupt status, 0x10 interrupt clear. Reads of the clear register and of unused offsets return 0.

Top module: `pgx_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `seq_req` and `irq` are low.
- R2: A write to transfer control with bit 0 set while idle starts a transfer. From the next cycle `seq_req` is high and the register reads back the written value. The outputs carry the written fields: bit 1 is `seq_to_flash` (1 means buffer to flash), bit 2 is `seq_main_en`, bit 3 is `seq_spare_en`, bits 6:4 are `seq_burst` (bursts of 4, 8 and 16), bit 7 is `seq_addr4` (four address cycles), and bits 9:8 are `seq_cs`.
- R3: The start bit stays at 1 until a cycle in which `seq_done` is high. From the next cycle it reads 0 and `seq_req` is low, and the other fields are kept.
- R4: While a transfer runs, `seq_op1`/`seq_op2` are 0x80/0x10 for a buffer-to-flash transfer and 0x00/0x30 for a flash-to-buffer transfer.
- R5: A write to transfer control while a transfer runs has no effect.
- R6: `seq_done` while idle has no effect: the transfer-done status bit stays 0.
- R7: Completion of a transfer sets status bit 9 (transfer done).
- R8: A pulse on `ecc_corr` sets status bit 5, and a pulse on `ecc_uncorr` sets status bit 6. Each sets even when its enable bit is 0.
- R9: `irq` is high exactly when some status bit among 9, 6 and 5 is set together with the enable bit at the same position. The enable register stores only bits 9, 6 and 5.
- R10: Writing 1 to bit 9, 6 or 5 of the clear register clears that status bit. Written zeros leave status bits unchanged.
- R11: If a set event and a clear write hit the same status bit in the same cycle, the bit ends set.
- R12: The length register stores the spare-area byte count in bits 27:16 and drives it on `seq_spare_len`. All other bits of the length register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| seq_req | output | 1 | Transfer request to the sequencer; the busy flag |
| seq_to_flash | output | 1 | 1 = buffer to flash, 0 = flash to buffer |
| seq_main_en | output | 1 | Main data area enabled |
| seq_spare_en | output | 1 | Spare area enabled |
| seq_burst | output | 3 | Burst enables for 4, 8 and 16 beats |
| seq_addr4 | output | 1 | Four address cycles |
| seq_cs | output | 2 | Chip select |
| seq_spare_len | output | 12 | Spare-area byte count |
| seq_op1 | output | 8 | First opcode of the transfer |
| seq_op2 | output | 8 | Second opcode of the transfer |
| seq_done | input | 1 | Sequencer completion pulse |
| ecc_corr | input | 1 | Corrected-error pulse from the ECC engine |
| ecc_uncorr | input | 1 | Uncorrectable-error pulse from the ECC engine |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default parameters: a 5-bit register address, a 12-bit spare-length field at bit 16 and a 2-bit chip select. With these values the bench can write the full spare field with all ones and read back exactly 0x0FFF0000. It can also drive the widest chip-select code into a transfer. The bench makes both transfer directions finish while interrupts are masked and while they are enabled. It makes one collision in which an ECC pulse and a clear write hit status bit 5 in the same cycle.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int NSRC = 3;
    // source index: 0 transfer done, 1 uncorrectable, 2 corrected
    localparam int SRC_POS [NSRC] = '{9, 6, 5};

    typedef enum logic [2:0] {
        RI_CTRL  = 3'd0,
        RI_LEN   = 3'd1,
        RI_IEN   = 3'd2,
        RI_ISTAT = 3'd3,
        RI_ICLR  = 3'd4
    } reg_idx_e;

    // packed to match transfer-control bits 9:1
    typedef struct packed {
        logic [1:0] cs;
        logic       addr4;
        logic [2:0] burst;
        logic       spare_en;
        logic       main_en;
        logic       to_flash;
    } xfer_cfg_t;

    function automatic logic [7:0] op_first(input logic to_flash);
        return to_flash ? 8'h80 : 8'h00;
    endfunction

    function automatic logic [7:0] op_second(input logic to_flash);
        return to_flash ? 8'h10 : 8'h30;
    endfunction

endpackage

// File: rtl/pgx_xfer.sv
module pgx_xfer
    import pgx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [9:0] ctrl_wdata,
    input  logic       seq_done,
    output logic       busy,
    output xfer_cfg_t  cfg,
    output logic       done_evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cfg  <= '0;
        end else if (busy) begin
            if (seq_done)
                busy <= 1'b0;
        end else if (ctrl_wr) begin
            cfg  <= xfer_cfg_t'(ctrl_wdata[9:1]);
            busy <= ctrl_wdata[0];
        end
    end

    assign done_evt = busy & seq_done;
endmodule

// File: rtl/pgx_irq.sv
module pgx_irq
    import pgx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NSRC-1:0] set_evt,
    input  logic          en_wr,
    input  logic          clr_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat_vec,
    output logic [DW-1:0] en_vec,
    output logic          irq
);
    logic [NSRC-1:0] st_q;
    logic [NSRC-1:0] en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int B = SRC_POS[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= 1'b0;
                en_q[i] <= 1'b0;
            end else begin
                if (set_evt[i])
                    st_q[i] <= 1'b1;
                else if (clr_wr && wdata[B])
                    st_q[i] <= 1'b0;
                if (en_wr)
                    en_q[i] <= wdata[B];
            end
        end
    end

    always_comb begin
        stat_vec = '0;
        en_vec   = '0;
        for (int i = 0; i < NSRC; i++) begin
            stat_vec[SRC_POS[i]] = st_q[i];
            en_vec[SRC_POS[i]]   = en_q[i];
        end
    end

    assign irq = |(st_q & en_q);
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int SPARE_W = 12,
    parameter int CS_W    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               seq_req,
    output logic               seq_to_flash,
    output logic               seq_main_en,
    output logic               seq_spare_en,
    output logic [2:0]         seq_burst,
    output logic               seq_addr4,
    output logic [CS_W-1:0]    seq_cs,
    output logic [SPARE_W-1:0] seq_spare_len,
    output logic [7:0]         seq_op1,
    output logic [7:0]         seq_op2,
    input  logic               seq_done,
    input  logic               ecc_corr,
    input  logic               ecc_uncorr,
    output logic               irq
);
    localparam int LEN_LSB = 16;
    localparam int LEN_MSB = LEN_LSB + SPARE_W - 1;
    localparam int IDX_W   = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr_ctrl, wr_len, wr_ien, wr_iclr;
    logic             busy, done_evt;
    xfer_cfg_t        cfg;
    logic [SPARE_W-1:0] spare_len_q;
    logic [DATA_W-1:0]  stat_q, ien_q;
    logic               unused_bits;

    assign idx     = reg_addr[ADDR_W-1:2];
    assign wr_ctrl = reg_we && idx == IDX_W'(RI_CTRL);
    assign wr_len  = reg_we && idx == IDX_W'(RI_LEN);
    assign wr_ien  = reg_we && idx == IDX_W'(RI_IEN);
    assign wr_iclr = reg_we && idx == IDX_W'(RI_ICLR);
    assign unused_bits = ^{reg_addr[1:0], reg_wdata};

    pgx_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wdata (reg_wdata[9:0]),
        .seq_done   (seq_done),
        .busy       (busy),
        .cfg        (cfg),
        .done_evt   (done_evt)
    );

    pgx_irq #(.DW(DATA_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_evt  ({ecc_corr, ecc_uncorr, done_evt}),
        .en_wr    (wr_ien),
        .clr_wr   (wr_iclr),
        .wdata    (reg_wdata),
        .stat_vec (stat_q),
        .en_vec   (ien_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            spare_len_q <= '0;
        else if (wr_len)
            spare_len_q <= reg_wdata[LEN_MSB:LEN_LSB];
    end

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_W'(RI_CTRL):  reg_rdata[9:0] = {cfg, busy};
            IDX_W'(RI_LEN):   reg_rdata[LEN_MSB:LEN_LSB] = spare_len_q;
            IDX_W'(RI_IEN):   reg_rdata = ien_q;
            IDX_W'(RI_ISTAT): reg_rdata = stat_q;
            default:          reg_rdata = '0;
        endcase
    end

    assign seq_req       = busy;
    assign seq_to_flash  = cfg.to_flash;
    assign seq_main_en   = cfg.main_en;
    assign seq_spare_en  = cfg.spare_en;
    assign seq_burst     = cfg.burst;
    assign seq_addr4     = cfg.addr4;
    assign seq_cs        = CS_W'(cfg.cs);
    assign seq_spare_len = spare_len_q;
    assign seq_op1       = op_first(cfg.to_flash);
    assign seq_op2       = op_second(cfg.to_flash);
endmodule

// File: rtl/pgx_ctrl_chk.sv
module pgx_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        seq_req,
    input logic        seq_done,
    input logic        seq_to_flash,
    input logic [1:0]  seq_cs,
    input logic [7:0]  seq_op1,
    input logic [7:0]  seq_op2,
    input logic        ecc_corr,
    input logic        ecc_uncorr,
    input logic        irq,
    input logic [31:0] stat_q,
    input logic [31:0] ien_q
);
    a_r3_req_holds: assert property (@(posedge clk) disable iff (rst)
        seq_req && !seq_done |=> seq_req);
    a_r3_req_drops: assert property (@(posedge clk) disable iff (rst)
        seq_req && seq_done |=> !seq_req);
    a_r7_done_sets: assert property (@(posedge clk) disable iff (rst)
        seq_req && seq_done |=> stat_q[9]);
    a_r8_corr_sets: assert property (@(posedge clk) disable iff (rst)
        ecc_corr |=> stat_q[5]);
    a_r8_uncorr_sets: assert property (@(posedge clk) disable iff (rst)
        ecc_uncorr |=> stat_q[6]);
    a_r4_opcodes: assert property (@(posedge clk) disable iff (rst)
        seq_req |-> (seq_to_flash ? (seq_op1 == 8'h80 && seq_op2 == 8'h10)
                                  : (seq_op1 == 8'h00 && seq_op2 == 8'h30)));
    a_r5_fields_frozen: assert property (@(posedge clk) disable iff (rst)
        seq_req |=> (!seq_req || ($stable(seq_cs) && $stable(seq_to_flash))));
    a_r9_no_irq_unmasked: assert property (@(posedge clk) disable iff (rst)
        !(|(stat_q & ien_q)) |-> !irq);
endmodule

bind pgx_ctrl pgx_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .seq_req      (seq_req),
    .seq_done     (seq_done),
    .seq_to_flash (seq_to_flash),
    .seq_cs       (seq_cs),
    .seq_op1      (seq_op1),
    .seq_op2      (seq_op2),
    .ecc_corr     (ecc_corr),
    .ecc_uncorr   (ecc_uncorr),
    .irq          (irq),
    .stat_q       (stat_q),
    .ien_q        (ien_q)
);

// File: tb/pgx_ctrl_test.sv
`timescale 1ns/1ps
module pgx_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_req, seq_to_flash, seq_main_en, seq_spare_en, seq_addr4;
    logic [2:0]  seq_burst;
    logic [1:0]  seq_cs;
    logic [11:0] seq_spare_len;
    logic [7:0]  seq_op1, seq_op2;
    logic        seq_done = 1'b0, ecc_corr = 1'b0, ecc_uncorr = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] A_CTRL = 5'h00, A_LEN = 5'h04, A_IEN = 5'h08,
                           A_ISTAT = 5'h0C, A_ICLR = 5'h10;

    always #2 clk = ~clk;

    pgx_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_req(seq_req),
        .seq_to_flash(seq_to_flash), .seq_main_en(seq_main_en),
        .seq_spare_en(seq_spare_en), .seq_burst(seq_burst),
        .seq_addr4(seq_addr4), .seq_cs(seq_cs), .seq_spare_len(seq_spare_len),
        .seq_op1(seq_op1), .seq_op2(seq_op2), .seq_done(seq_done),
        .ecc_corr(ecc_corr), .ecc_uncorr(ecc_uncorr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_LEN, v);   chk("R1 len", v, 0);
        rd(A_IEN, v);   chk("R1 ien", v, 0);
        rd(A_ISTAT, v); chk("R1 istat", v, 0);
        chk("R1 req/irq", {seq_req, irq}, 0);
    endtask

    task automatic t_length();
        logic [31:0] v;
        wr(A_LEN, 32'h0040_0000);
        rd(A_LEN, v); chk("R12 len readback", v, 32'h0040_0000);
        chk("R12 spare out", seq_spare_len, 12'h040);
        wr(A_LEN, 32'hFFFF_FFFF);
        rd(A_LEN, v); chk("R12 len masked", v, 32'h0FFF_0000);
        chk("R12 spare out full", seq_spare_len, 12'hFFF);
    endtask

    task automatic t_read_xfer();
        logic [31:0] v;
        wr(A_CTRL, 32'h2FD);
        chk("R2 req", seq_req, 1);
        rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h2FD);
        chk("R2 fields", {seq_cs, seq_addr4, seq_burst, seq_spare_en, seq_main_en, seq_to_flash},
            {2'b10, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0});
        chk("R4 read ops", {seq_op1, seq_op2}, 16'h0030);
        wr(A_CTRL, 32'h003);
        rd(A_CTRL, v); chk("R5 write while busy", v, 32'h2FD);
        repeat (3) @(negedge clk);
        chk("R3 still busy", seq_req, 1);
        pulse_done();
        chk("R3 req drops", seq_req, 0);
        rd(A_CTRL, v); chk("R3 start cleared", v, 32'h2FC);
        rd(A_ISTAT, v); chk("R7 done status", v, 32'h200);
        chk("R9 masked irq", irq, 0);
    endtask

    task automatic t_prog_xfer();
        logic [31:0] v;
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, v); chk("R9 ien stored bits", v, 32'h260);
        chk("R9 irq pending done", irq, 1);
        wr(A_ICLR, 32'h200);
        rd(A_ISTAT, v); chk("R10 clear done", v, 0);
        chk("R9 irq low", irq, 0);
        wr(A_CTRL, 32'h003);
        chk("R4 program ops", {seq_op1, seq_op2}, 16'h8010);
        pulse_done();
        chk("R9 irq on done", irq, 1);
        wr(A_ICLR, 32'h0);
        rd(A_ISTAT, v); chk("R10 zero write", v, 32'h200);
        wr(A_ICLR, 32'h200);
        rd(A_ISTAT, v); chk("R10 clear", v, 0);
        chk("R10 irq cleared", irq, 0);
    endtask

    task automatic t_idle_done();
        logic [31:0] v;
        pulse_done();
        rd(A_ISTAT, v); chk("R6 idle done ignored", v, 0);
        chk("R6 req stays low", seq_req, 0);
    endtask

    task automatic t_ecc();
        logic [31:0] v;
        wr(A_IEN, 32'h0);
        @(negedge clk); ecc_corr = 1'b1;
        @(negedge clk); ecc_corr = 1'b0;
        rd(A_ISTAT, v); chk("R8 corr masked set", v, 32'h20);
        chk("R9 irq masked", irq, 0);
        @(negedge clk); ecc_uncorr = 1'b1;
        @(negedge clk); ecc_uncorr = 1'b0;
        rd(A_ISTAT, v); chk("R8 uncorr set", v, 32'h60);
        wr(A_IEN, 32'h40);
        chk("R9 irq uncorr", irq, 1);
        wr(A_ICLR, 32'h40);
        rd(A_ISTAT, v); chk("R10 clear uncorr only", v, 32'h20);
        chk("R9 irq after clear", irq, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_ICLR; reg_wdata = 32'h20; ecc_corr = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; ecc_corr = 1'b0;
        rd(A_ISTAT, v); chk("R11 set wins", v, 32'h20);
        wr(A_ICLR, 32'h20);
        rd(A_ISTAT, v); chk("R11 later clear", v, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung, expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_length();
        t_read_xfer();
        t_prog_xfer();
        t_idle_done();
        t_ecc();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule